// File: doc/BRIEF.md
# Dual-Bank Multi-Port Register File

This block is a register file with two write ports that update on the clock edge and three read ports that return data combinationally. Its storage is laid out so that a synthesis tool can place it in LUT-based distributed RAM. Each kind of distributed RAM cell takes only one write per cycle, so the block keeps two banks. Write port A always writes bank A and write port B always writes bank B, and no multiplexer sits in front of the write data.

A flag register per word records which bank took the most recent write to that word. Every read port uses the flag of the word it addresses to choose between the two banks. Taken together, the block behaves like a single memory with two write ports and three read ports.

The default holds 32 integer words of `DATA_W` bits. Word 0 reads as zero and cannot be written. A parameter adds 32 more words for floating-point registers at addresses 32 to 63. These words have no zero register, and the address and the flag array grow with them.

Top module: `rf_dual_bank`

## Requirements
- R1: A write takes effect at the rising clock edge. A read of the same address in the cycle of the write returns the old value, and the new value is readable from the next cycle.
- R2: The three read ports are combinational and each has its own address. All three may read different words in the same cycle.
- R3: Port A stores only into bank A and port B stores only into bank B. Every read returns the data of whichever port last wrote the addressed word.
- R4: If both write ports are enabled for the same nonzero address in one cycle, reads return port B's data afterwards. Bank A still takes port A's data, and the flag points to bank B.
- R5: Address 0 always reads as zero on every read port. Writes to it change neither bank nor the flag array.
- R6: The active-low reset clears every flag to bank A and leaves bank contents unchanged. After reset each word reads the last data port A wrote to it.
- R7: A write port with its enable low changes nothing, whatever its address and data.
- R8: With `FP_EN`=1 the file has 64 words on a 6-bit address, and words 32 to 63 are ordinary writable words. With `FP_EN`=0 it has 32 words on a 5-bit address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset of the flag array |
| rdAddr0 | input | ADDR_W | Read port 0 address |
| rdData0 | output | DATA_W | Read port 0 data |
| rdAddr1 | input | ADDR_W | Read port 1 address |
| rdData1 | output | DATA_W | Read port 1 data |
| rdAddr2 | input | ADDR_W | Read port 2 address |
| rdData2 | output | DATA_W | Read port 2 data |
| wrAddrA | input | ADDR_W | Write port A address |
| wrDataA | input | DATA_W | Write port A data |
| wrEnA | input | 1 | Write port A enable |
| wrAddrB | input | ADDR_W | Write port B address |
| wrDataB | input | DATA_W | Write port B data |
| wrEnB | input | 1 | Write port B enable |

## Verification
The bench runs a 16-bit, 64-word configuration and sweeps every address through port A, then port B, then a same-address collision.

- **Collision:** a design that lets port A win a same-address collision, or that leaves the flag unset, returns port A's data after the collision.
- **Same-cycle read:** a read-during-write check catches a read path that forwards the new value early.
- **Reset:** a reset in the middle of the run exposes a design that clears bank contents, or leaves flags pointing at bank B. In either case the post-reset values stop matching the last port-A data.
- **Address 0:** writes to address 0 are checked at the read ports, where a design that stores them would read back nonzero.
- **Random traffic:** long random concurrent traffic with forced collisions catches selector indexing slips, such as reading the wrong word's flag.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int NUM_RD = 3;
  localparam int INT_WORDS = 32;
  localparam int FP_WORDS = 32;

  // Strobes from control to datapath
  typedef struct packed {
    logic              bankWeA;
    logic              bankWeB;
    logic [NUM_RD-1:0] rdSelB;
  } rfStrobeT;
endpackage

// File: rtl/rf_bank_ctrl.sv
module rf_bank_ctrl
  import rf_pkg::*;
#(
  parameter int NUM_WORDS = 32,
  parameter int ADDR_W = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  rdAddr [NUM_RD],
  input  logic [ADDR_W-1:0]  wrAddrA,
  input  logic               wrEnA,
  input  logic [ADDR_W-1:0]  wrAddrB,
  input  logic               wrEnB,
  output rfStrobeT           strobe
);
  logic effA;
  logic effB;
  logic [NUM_WORDS-1:0] lastB;

  // Address 0 is the constant-zero integer register
  assign effA = wrEnA && (wrAddrA != '0);
  assign effB = wrEnB && (wrAddrB != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastB <= '0;
    end else begin
      if (effA) lastB[wrAddrA] <= 1'b0;
      if (effB) lastB[wrAddrB] <= 1'b1;  // later assignment: port B wins
    end
  end

  always_comb begin
    strobe.bankWeA = effA;
    strobe.bankWeB = effB;
    for (int i = 0; i < NUM_RD; i++) begin
      strobe.rdSelB[i] = lastB[rdAddr[i]];
    end
  end
endmodule

// File: rtl/rf_bank_data.sv
module rf_bank_data
  import rf_pkg::*;
#(
  parameter int NUM_WORDS = 32,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  rfStrobeT           strobe,
  input  logic [ADDR_W-1:0]  rdAddr [NUM_RD],
  output logic [DATA_W-1:0]  rdData [NUM_RD],
  input  logic [ADDR_W-1:0]  wrAddrA,
  input  logic [DATA_W-1:0]  wrDataA,
  input  logic [ADDR_W-1:0]  wrAddrB,
  input  logic [DATA_W-1:0]  wrDataB
);
  logic [DATA_W-1:0] bankA [NUM_WORDS];
  logic [DATA_W-1:0] bankB [NUM_WORDS];

  // No reset: distributed RAM has none
  always_ff @(posedge clk) begin
    if (strobe.bankWeA) bankA[wrAddrA] <= wrDataA;
  end

  always_ff @(posedge clk) begin
    if (strobe.bankWeB) bankB[wrAddrB] <= wrDataB;
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    logic [DATA_W-1:0] pick;
    assign pick = strobe.rdSelB[p] ? bankB[rdAddr[p]] : bankA[rdAddr[p]];
    assign rdData[p] = (rdAddr[p] == '0) ? '0 : pick;
  end
endmodule

// File: rtl/rf_dual_bank.sv
module rf_dual_bank
  import rf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter bit FP_EN = 1'b0,
  localparam int NUM_WORDS = INT_WORDS + (FP_EN ? FP_WORDS : 0),
  localparam int ADDR_W = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] rdAddr0,
  output logic [DATA_W-1:0] rdData0,
  input  logic [ADDR_W-1:0] rdAddr1,
  output logic [DATA_W-1:0] rdData1,
  input  logic [ADDR_W-1:0] rdAddr2,
  output logic [DATA_W-1:0] rdData2,
  input  logic [ADDR_W-1:0] wrAddrA,
  input  logic [DATA_W-1:0] wrDataA,
  input  logic              wrEnA,
  input  logic [ADDR_W-1:0] wrAddrB,
  input  logic [DATA_W-1:0] wrDataB,
  input  logic              wrEnB
);
  logic [ADDR_W-1:0] rdAddr [NUM_RD];
  logic [DATA_W-1:0] rdData [NUM_RD];
  rfStrobeT strobe;

  assign rdAddr[0] = rdAddr0;
  assign rdAddr[1] = rdAddr1;
  assign rdAddr[2] = rdAddr2;
  assign rdData0 = rdData[0];
  assign rdData1 = rdData[1];
  assign rdData2 = rdData[2];

  rf_bank_ctrl #(.NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .rdAddr(rdAddr),
    .wrAddrA(wrAddrA), .wrEnA(wrEnA),
    .wrAddrB(wrAddrB), .wrEnB(wrEnB),
    .strobe(strobe)
  );

  rf_bank_data #(.NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk(clk), .strobe(strobe), .rdAddr(rdAddr), .rdData(rdData),
    .wrAddrA(wrAddrA), .wrDataA(wrDataA),
    .wrAddrB(wrAddrB), .wrDataB(wrDataB)
  );
endmodule

// File: rtl/rf_dual_bank_chk.sv
module rf_dual_bank_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] rdAddr0,
  input logic [DATA_W-1:0] rdData0,
  input logic [ADDR_W-1:0] rdAddr1,
  input logic [DATA_W-1:0] rdData1,
  input logic [ADDR_W-1:0] rdAddr2,
  input logic [DATA_W-1:0] rdData2,
  input logic [ADDR_W-1:0] wrAddrA,
  input logic [DATA_W-1:0] wrDataA,
  input logic              wrEnA,
  input logic [ADDR_W-1:0] wrAddrB,
  input logic [DATA_W-1:0] wrDataB,
  input logic              wrEnB
);
  a_r5_zero_rd0: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr0 == '0) |-> (rdData0 == '0));
  a_r5_zero_rd1: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr1 == '0) |-> (rdData1 == '0));
  a_r5_zero_rd2: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr2 == '0) |-> (rdData2 == '0));

  a_r3_port_a_lands: assert property (@(posedge clk) disable iff (!rstN)
    (wrEnA && wrAddrA != '0 && !(wrEnB && wrAddrB == wrAddrA))
    |=> ((rdAddr0 == $past(wrAddrA)) -> (rdData0 == $past(wrDataA))));

  a_r3_port_b_lands: assert property (@(posedge clk) disable iff (!rstN)
    (wrEnB && wrAddrB != '0)
    |=> ((rdAddr2 == $past(wrAddrB)) -> (rdData2 == $past(wrDataB))));

  a_r4_b_wins: assert property (@(posedge clk) disable iff (!rstN)
    (wrEnA && wrEnB && wrAddrA == wrAddrB && wrAddrB != '0)
    |=> ((rdAddr1 == $past(wrAddrB)) -> (rdData1 == $past(wrDataB))));

  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!wrEnA && !wrEnB) && $stable(rdAddr2)) |-> $stable(rdData2));
endmodule

bind rf_dual_bank rf_dual_bank_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN),
  .rdAddr0(rdAddr0), .rdData0(rdData0),
  .rdAddr1(rdAddr1), .rdData1(rdData1),
  .rdAddr2(rdAddr2), .rdData2(rdData2),
  .wrAddrA(wrAddrA), .wrDataA(wrDataA), .wrEnA(wrEnA),
  .wrAddrB(wrAddrB), .wrDataB(wrDataB), .wrEnB(wrEnB)
);

// File: tb/tb_rf_dual_bank.sv
module tb_rf_dual_bank;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int AW = 6;
  localparam int NW = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [AW-1:0] rdAddr0 = '0, rdAddr1 = '0, rdAddr2 = '0;
  logic [DW-1:0] rdData0, rdData1, rdData2;
  logic [AW-1:0] wrAddrA = '0, wrAddrB = '0;
  logic [DW-1:0] wrDataA = '0, wrDataB = '0;
  logic wrEnA = 1'b0, wrEnB = 1'b0;

  int nChecks = 0;
  int nFails = 0;

  // Model built from R3/R4/R5/R6: two bank images and a newest-bank flag
  logic [DW-1:0] refA [NW];
  logic [DW-1:0] refB [NW];
  logic refSel [NW];

  always #(CLK_PERIOD/2) clk = ~clk;

  rf_dual_bank #(.DATA_W(DW), .FP_EN(1'b1)) dut (
    .clk(clk), .rstN(rstN),
    .rdAddr0(rdAddr0), .rdData0(rdData0),
    .rdAddr1(rdAddr1), .rdData1(rdData1),
    .rdAddr2(rdAddr2), .rdData2(rdData2),
    .wrAddrA(wrAddrA), .wrDataA(wrDataA), .wrEnA(wrEnA),
    .wrAddrB(wrAddrB), .wrDataB(wrDataB), .wrEnB(wrEnB)
  );

  function automatic logic [DW-1:0] expWord(input int a);
    if (a == 0) return '0;
    return refSel[a] ? refB[a] : refA[a];
  endfunction

  task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic readAll(input int a0, input int a1, input int a2, input string tag);
    rdAddr0 = AW'(a0); rdAddr1 = AW'(a1); rdAddr2 = AW'(a2);
    #1;
    check(rdData0, expWord(a0), tag);
    check(rdData1, expWord(a1), tag);
    check(rdData2, expWord(a2), tag);
  endtask

  // Called at a falling edge; returns at the next falling edge
  task automatic wr(input logic eA, input int aA, input logic [DW-1:0] dA,
                    input logic eB, input int aB, input logic [DW-1:0] dB);
    wrEnA = eA; wrAddrA = AW'(aA); wrDataA = dA;
    wrEnB = eB; wrAddrB = AW'(aB); wrDataB = dB;
    @(posedge clk);
    if (eA && aA != 0) begin refA[aA] = dA; refSel[aA] = 1'b0; end
    if (eB && aB != 0) begin refB[aB] = dB; refSel[aB] = 1'b1; end
    @(negedge clk);
    wrEnA = 1'b0; wrEnB = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NW; i++) refSel[i] = 1'b0;
    repeat (3) @(negedge clk);
    // Reset state: address 0 reads zero (R5)
    readAll(0, 0, 0, "R5 reset zero");
    rstN = 1'b1;
    @(negedge clk);

    // Fill every word through port A (R1, R3, R8: words 32..63 writable)
    for (int a = 1; a < NW; a++) begin
      wr(1'b1, a, DW'(a * 16'h0101 ^ 16'h5a3c), 1'b0, 0, '0);
      readAll(a, (a + 1) % NW == 0 ? 0 : a - 1, a, "R3 port A fill");
    end
    // Three distinct addresses at once (R2, R8)
    readAll(0, 32, 63, "R8 fp half");
    readAll(5, 37, 1, "R2 independent reads");

    // Port B overwrites even words (R3)
    for (int a = 2; a < NW; a += 2) wr(1'b0, 0, '0, 1'b1, a, DW'(a * 16'h0313 + 16'h0077));
    for (int a = 1; a < NW; a++) readAll(a, NW - 1 - a, (a * 7) % NW, "R3 port B newest");

    // Port A rewrites words 4 and 40 after port B (R3)
    wr(1'b1, 4, 16'hA004, 1'b0, 0, '0);
    wr(1'b1, 40, 16'hA040, 1'b0, 0, '0);
    readAll(4, 40, 6, "R3 port A newest again");

    // Collisions on every address: port B wins (R4)
    for (int a = 1; a < NW; a++) begin
      wr(1'b1, a, DW'(16'hC000 + a), 1'b1, a, DW'(16'hD000 + a));
      readAll(a, a, a, "R4 collision B wins");
    end

    // Writes to address 0 ignored (R5)
    wr(1'b1, 0, 16'hFFFF, 1'b1, 0, 16'hEEEE);
    readAll(0, 0, 1, "R5 zero write ignored");

    // Disabled ports change nothing (R7)
    wr(1'b0, 9, 16'h1234, 1'b0, 10, 16'h5678);
    readAll(9, 10, 11, "R7 disabled write");

    // Same-cycle read returns old value (R1)
    wrEnA = 1'b1; wrAddrA = AW'(12); wrDataA = 16'hBEEF;
    rdAddr0 = AW'(12);
    #1;
    check(rdData0, expWord(12), "R1 old value in write cycle");
    @(posedge clk);
    refA[12] = 16'hBEEF; refSel[12] = 1'b0;
    @(negedge clk);
    wrEnA = 1'b0;
    check(rdData0, 16'hBEEF, "R1 new value next cycle");

    // Reset keeps banks, flags return to bank A (R6)
    wr(1'b1, 7, 16'h1111, 1'b0, 0, '0);
    wr(1'b0, 0, '0, 1'b1, 7, 16'h2222);
    readAll(7, 7, 7, "R6 before reset");
    rstN = 1'b0;
    for (int i = 0; i < NW; i++) refSel[i] = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(rdData0, 16'h1111, "R6 bank A after reset");
    for (int a = 1; a < NW; a++) readAll(a, a, a, "R6 all words after reset");

    // Random concurrent traffic with forced collisions (R2, R3, R4)
    for (int n = 0; n < 3000; n++) begin
      int aA, aB;
      aA = int'($urandom % NW);
      aB = ($urandom % 4 == 0) ? aA : int'($urandom % NW);
      wr(1'($urandom), aA, DW'($urandom), 1'($urandom), aB, DW'($urandom));
      readAll(aA, aB, int'($urandom % NW), "R4 random traffic");
    end

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule